// File: doc/BRIEF.md
# Instruction Front End with Decode-Stage Next-PC Resolution

This block is the first two stages of a small pipelined 32-bit RISC core. The fetch stage holds the program counter and drives it straight to an instruction memory port that answers in the same cycle. The returned word is captured in a fetch/decode register together with the address it came from.

The decode stage decides where the program goes next. A zero test on the first register operand resolves conditional branches. Jumps and taken branches add a scaled immediate to the address of the control instruction. Register-indirect jumps take their target directly from the register file. An instruction that was fetched on the wrong path is squashed and leaves a one-cycle bubble.

The decode stage also reads two operands from a 32-entry register file and forwards them with a destination index and a valid flag. For linking jumps, the second operand is replaced by the return address. The later pipeline stages write results back through a single write port.

Top module: `fdu_front`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and the decode stage becomes empty. After such an edge, `imemAddr` reads 0 and `decValid` reads 0.
- R2: `imemAddr` always shows the PC. At each rising edge without a redirect, the fetched word enters decode with `decValid` = 1 and the PC advances by 4. Decoding the instruction at address P in that case shows `imemAddr` = P+4.
- R3: Opcode 6'h04 (bits 31:26) is a branch taken when register rs (bits 25:21) reads zero. Its target is P + (sign-extended bits 15:0 shifted left by 2), where P is the branch's own address.
- R4: Opcode 6'h05 is a branch with the same target rule that is taken when register rs is non-zero.
- R5: Opcodes 6'h02 (plain jump) and 6'h03 (linking jump) always redirect to the same relative target as R3. This includes negative offsets.
- R6: Opcode 6'h00 with function field (bits 5:0) 6'h08 (plain) or 6'h09 (linking) redirects to the value of register rs.
- R7: The word fetched in the cycle that a redirect is decoded is discarded. In the next cycle `decValid` is 0 and `imemAddr` shows the target.
- R8: For a linking jump (opcode 6'h03, or function 6'h09 under opcode 6'h00) at address P, `decOpB` is P+4 instead of a register value. The destination is 31 for opcode 6'h03 and rd (bits 15:11) for function 6'h09.
- R9: `decOpA` is register rs and `decOpB` is register rt (bits 20:16). The destination is set as follows:
  - rd for opcode 6'h00, except function 6'h08;
  - 0 for opcodes 6'h02, 6'h04, 6'h05 and for function 6'h08;
  - rt for any other opcode.
- R10: A write with `wrEn` high stores `wrData` into register `wrIdx` at the rising edge, whether or not `rst` is high. Register 0 always reads 0, even after a write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of PC and decode register |
| imemAddr | output | 32 | Fetch address to instruction memory |
| imemData | input | 32 | Instruction word returned for `imemAddr` |
| wrEn | input | 1 | Register file write enable |
| wrIdx | input | 5 | Register file write index |
| wrData | input | 32 | Register file write data |
| decOpA | output | 32 | First decoded operand |
| decOpB | output | 32 | Second decoded operand or return address |
| decDest | output | 5 | Destination register index |
| decValid | output | 1 | Decode stage holds a live instruction |

## Verification
Several rules are checked on every cycle:
- the reset state;
- sequential PC advance when nothing redirects;
- the bubble after every redirect;
- register-indirect targets;
- the link value against the previous fetch address;
- the constant-zero register.

Only the bench's program can show that the correct branch direction is chosen for each zero-test outcome, that relative targets land where the offset says, and that destinations follow each instruction class. It does this by running a program with taken, not-taken and negative-offset transfers against an in-order reference model.

// File: rtl/fdu_pkg.sv
package fdu_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JREL    = 6'h02;
  localparam logic [5:0] OP_JRELLNK = 6'h03;
  localparam logic [5:0] OP_BRZ     = 6'h04;
  localparam logic [5:0] OP_BRNZ    = 6'h05;
  localparam logic [5:0] FN_JREG    = 6'h08;
  localparam logic [5:0] FN_JREGLNK = 6'h09;

  typedef enum logic [1:0] {
    DEST_NONE,
    DEST_RT,
    DEST_RD,
    DEST_LINK
  } destSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     condEq;   // taken when operand A is zero
    logic     condNe;   // taken when operand A is non-zero
    logic     relJump;  // unconditional relative transfer
    logic     regJump;  // register-indirect transfer
    logic     link;     // substitute return address for operand B
    destSel_e destSel;
  } ctrl_t;

endpackage

// File: rtl/fdu_regfile.sv
module fdu_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [XLEN-1:0] wrData,
  input  logic [IDXW-1:0] rdIdxA,
  output logic [XLEN-1:0] rdDataA,
  input  logic [IDXW-1:0] rdIdxB,
  output logic [XLEN-1:0] rdDataB
);

  logic [XLEN-1:0] rf [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    if (g == 0) begin : gZero
      assign rf[g] = '0;
    end else begin : gStore
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (wrEn && wrIdx == IDXW'(g)) q <= wrData;
      end
      assign rf[g] = q;
    end
  end

  assign rdDataA = rf[rdIdxA];
  assign rdDataB = rf[rdIdxB];

  always_comb begin
    // R10
    if (rdIdxA == '0) zero_reg_chk: assert (rdDataA == '0);
  end

  // R10
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx != '0) |=> rf[$past(wrIdx)] == $past(wrData));

endmodule

// File: rtl/fdu_control.sv
module fdu_control
  import fdu_pkg::*;
(
  input  logic       valid,
  input  logic [5:0] opField,
  input  logic [5:0] fnField,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.destSel = DEST_RT;
    unique case (opField)
      OP_SPECIAL: begin
        ctrl.destSel = DEST_RD;
        if (fnField == FN_JREG) begin
          ctrl.regJump = 1'b1;
          ctrl.destSel = DEST_NONE;
        end else if (fnField == FN_JREGLNK) begin
          ctrl.regJump = 1'b1;
          ctrl.link    = 1'b1;
        end
      end
      OP_JREL: begin
        ctrl.relJump = 1'b1;
        ctrl.destSel = DEST_NONE;
      end
      OP_JRELLNK: begin
        ctrl.relJump = 1'b1;
        ctrl.link    = 1'b1;
        ctrl.destSel = DEST_LINK;
      end
      OP_BRZ: begin
        ctrl.condEq  = 1'b1;
        ctrl.destSel = DEST_NONE;
      end
      OP_BRNZ: begin
        ctrl.condNe  = 1'b1;
        ctrl.destSel = DEST_NONE;
      end
      default: ;
    endcase
    if (!valid) begin
      ctrl         = '0;
      ctrl.destSel = DEST_NONE;
    end
  end

  always_comb begin
    // R5
    xfer_kind_chk: assert ($onehot0({ctrl.condEq, ctrl.condNe, ctrl.relJump, ctrl.regJump}));
  end

endmodule

// File: rtl/fdu_datapath.sv
module fdu_datapath
  import fdu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  parameter int ILEN  = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int STEP = ILEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imemAddr,
  input  logic [ILEN-1:0] imemData,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [XLEN-1:0] wrData,
  input  ctrl_t           ctrl,
  output logic            validD,
  output logic [5:0]      opD,
  output logic [5:0]      fnD,
  output logic [XLEN-1:0] opA,
  output logic [XLEN-1:0] opB,
  output logic [IDXW-1:0] dest
);

  localparam logic [ILEN-1:0] NOP_WORD = '0;

  logic [XLEN-1:0] pcQ, pcD;
  logic [ILEN-1:0] instrD;
  logic [XLEN-1:0] regA, regB;
  logic [XLEN-1:0] seqPc, brTarget, innerPc, nextPc, linkPc, offset;
  logic            zeroDet, innerSel, redirect;
  logic [4:0]      rsF, rtF, rdF;
  logic [15:0]     immF;

  assign rsF  = instrD[25:21];
  assign rtF  = instrD[20:16];
  assign rdF  = instrD[15:11];
  assign immF = instrD[15:0];
  assign opD  = instrD[31:26];
  assign fnD  = instrD[5:0];

  fdu_regfile #(.XLEN(XLEN), .DEPTH(DEPTH)) i_rf (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .rdIdxA (IDXW'(rsF)),
    .rdDataA(regA),
    .rdIdxB (IDXW'(rtF)),
    .rdDataB(regB)
  );

  // next-PC arithmetic
  assign offset   = {{(XLEN-18){immF[15]}}, immF, 2'b00};
  assign seqPc    = pcQ + XLEN'(STEP);
  assign brTarget = pcD + offset;
  assign linkPc   = pcD + XLEN'(STEP);
  assign zeroDet  = (regA == '0);

  // inner mux: sequential vs relative, steered by the zero detector
  assign innerSel = ctrl.relJump | (ctrl.condEq & zeroDet) | (ctrl.condNe & ~zeroDet);
  assign innerPc  = innerSel ? brTarget : seqPc;
  // outer mux: register-indirect bypass
  assign nextPc   = ctrl.regJump ? regA : innerPc;
  assign redirect = innerSel | ctrl.regJump;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ    <= '0;
      pcD    <= '0;
      instrD <= NOP_WORD;
      validD <= 1'b0;
    end else begin
      pcQ    <= nextPc;
      pcD    <= pcQ;
      instrD <= redirect ? NOP_WORD : imemData;
      validD <= ~redirect;
    end
  end

  assign imemAddr = pcQ;
  assign opA      = regA;
  assign opB      = ctrl.link ? linkPc : regB;

  always_comb begin
    unique case (ctrl.destSel)
      DEST_RT:   dest = IDXW'(rtF);
      DEST_RD:   dest = IDXW'(rdF);
      DEST_LINK: dest = IDXW'(DEPTH - 1);
      default:   dest = '0;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pcQ == '0 && !validD));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pcQ == $past(pcQ) + XLEN'(STEP));

  // R7
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !validD);

  // R6
  reg_target_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.regJump |=> pcQ == $past(regA));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    (validD && ctrl.link) |-> opB == $past(pcQ) + XLEN'(STEP));

endmodule

// File: rtl/fdu_front.sv
module fdu_front
  import fdu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imemAddr,
  input  logic [31:0]     imemData,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] decOpA,
  output logic [XLEN-1:0] decOpB,
  output logic [IDXW-1:0] decDest,
  output logic            decValid
);

  ctrl_t      ctrl;
  logic [5:0] opD, fnD;

  fdu_control i_ctrl (
    .valid  (decValid),
    .opField(opD),
    .fnField(fnD),
    .ctrl   (ctrl)
  );

  fdu_datapath #(.XLEN(XLEN), .DEPTH(DEPTH), .ILEN(32)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .imemAddr(imemAddr),
    .imemData(imemData),
    .wrEn    (wrEn),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .ctrl    (ctrl),
    .validD  (decValid),
    .opD     (opD),
    .fnD     (fnD),
    .opA     (decOpA),
    .opB     (decOpB),
    .dest    (decDest)
  );

endmodule

// File: tb/test_fdu_front.sv
module test_fdu_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] decOpA, decOpB;
  logic [4:0]  decDest;
  logic        decValid;

  always #2 clk = ~clk;

  fdu_front i_fdu_front (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .decOpA(decOpA), .decOpB(decOpB), .decDest(decDest), .decValid(decValid)
  );

  logic [31:0] progMem [32];
  assign imemData = (imemAddr < 32'd128) ? progMem[imemAddr[6:2]] : 32'h0;

  typedef struct {
    logic        valid;
    logic [31:0] addr;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  dst;
    string       tag;
  } item_t;

  item_t       expQ[$];
  logic [31:0] refRegs [32];
  int          nCompared = 0;
  int          nMismatch = 0;
  bit          finished  = 1'b0;

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: reference model of in-order execution, pushes one item per decode cycle
  task automatic buildExpected(input int steps);
    logic [31:0] pc = 32'h0;
    item_t it;
    it = '{1'b0, 32'h0, 32'h0, 32'h0, 5'd0, "R1"};
    expQ.push_back(it);
    for (int s = 0; s < steps; s++) begin
      logic [31:0] ins, off, tgt;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd;
      logic        taken;
      ins = progMem[pc[6:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      off = {{14{ins[15]}}, ins[15:0], 2'b00};
      taken = 1'b0; tgt = pc + off;
      it = '{1'b1, pc + 32'd4, refRegs[rs], refRegs[rt], rt, "R9"};
      if (op == 6'h00) begin
        it.dst = rd;
        if (fn == 6'h08) begin taken = 1; tgt = refRegs[rs]; it.dst = 0; it.tag = "R6"; end
        if (fn == 6'h09) begin taken = 1; tgt = refRegs[rs]; it.b = pc + 4; it.tag = "R8"; end
      end else if (op == 6'h02) begin taken = 1; it.dst = 0; it.tag = "R5"; end
      else if (op == 6'h03) begin taken = 1; it.dst = 31; it.b = pc + 4; it.tag = "R8"; end
      else if (op == 6'h04) begin taken = (refRegs[rs] == 0); it.dst = 0; it.tag = "R3"; end
      else if (op == 6'h05) begin taken = (refRegs[rs] != 0); it.dst = 0; it.tag = "R4"; end
      if (rs == 0 && op != 6'h00) it.tag = (it.tag == "R9") ? "R10" : it.tag;
      expQ.push_back(it);
      if (taken) begin
        it = '{1'b0, tgt, 32'h0, 32'h0, 5'd0, "R7"};
        expQ.push_back(it);
        pc = tgt;
      end else begin
        pc = pc + 4;
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 32; k++) progMem[k] = encI(6'h08, 5'd1, 5'd1, 16'h0);
    progMem[0]  = encR(5'd2, 5'd4, 5'd6, 6'h20);       // register op, dest rd
    progMem[1]  = encI(6'h04, 5'd1, 5'd0, 16'd3);      // zero-branch taken -> 0x10
    progMem[2]  = encI(6'h08, 5'd2, 5'd3, 16'd5);
    progMem[4]  = encI(6'h04, 5'd2, 5'd0, 16'd5);      // zero-branch not taken
    progMem[5]  = encI(6'h05, 5'd2, 5'd0, 16'd2);      // nonzero-branch taken -> 0x1C
    progMem[7]  = encI(6'h03, 5'd0, 5'd0, 16'd2);      // linking relative jump -> 0x24
    progMem[9]  = encR(5'd3, 5'd0, 5'd0, 6'h08);       // indirect jump -> r3
    progMem[12] = encR(5'd5, 5'd0, 5'd9, 6'h09);       // linking indirect -> r5
    progMem[20] = encI(6'h05, 5'd0, 5'd2, 16'd4);      // nonzero-branch on r0 not taken
    progMem[21] = encI(6'h02, 5'd0, 5'd0, 16'hFFEB);   // back to 0x00
    for (int k = 0; k < 32; k++) refRegs[k] = 32'h0101 * k;
    refRegs[0] = 0; refRegs[1] = 0; refRegs[2] = 7;
    refRegs[3] = 32'h30; refRegs[4] = 32'h1234; refRegs[5] = 32'h50;
  end

  // stimulus and monitor
  initial begin
    repeat (2) @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      wrEn = 1'b1; wrIdx = 5'(k);
      wrData = (k == 0) ? 32'd99 : refRegs[k];
      @(negedge clk);
    end
    wrEn = 1'b0;
    // R1: reset state after edges with rst high
    check("R1", "imemAddr", imemAddr, 32'h0);
    check("R1", "decValid", {31'd0, decValid}, 32'h0);
    buildExpected(40);
    rst = 1'b0;
    while (expQ.size() > 0) begin
      item_t e;
      #1;
      e = expQ.pop_front();
      check(e.tag, "decValid", {31'd0, decValid}, {31'd0, e.valid});
      check(e.tag, "imemAddr", imemAddr, e.addr);
      if (e.valid) begin
        check(e.tag, "decOpA", decOpA, e.a);
        check(e.tag, "decOpB", decOpB, e.b);
        check(e.tag, "decDest", {27'd0, decDest}, {27'd0, e.dst});
      end
      @(negedge clk);
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nCompared++; nMismatch++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule